// File: doc/BRIEF.md
# Video Timing Measurement Unit

This block measures where picture content sits relative to the horizontal and vertical flyback pulses of an incoming video signal. A single video-active bit, produced outside the block by comparing the colour inputs against a software-set threshold, is sampled once per pixel clock. For each line the block finds the first and last active pixel and derives the back porch, the active width and the front porch. For each frame it does the same with whole lines as the unit, where a line counts as active if any of its pixels was.

All six figures are 12-bit counts that saturate at 4095. They are copied into a read-only bank only when a frame ends, so a host that reads them byte by byte always sees six values from the same frame. A monitor controller uses the figures to centre and size the picture automatically.

Top module: `vtm_measure`

## Requirements
- R1: After reset every readable byte returns 0.
- R2: A flyback input restarts its measurement only on a low-to-high transition (the first clock it is seen high). Holding it high for further clocks starts nothing.
- R3: Horizontal units are pixel clocks, numbered 0 from the clock after a horizontal edge. The clock that carries the next edge is the last unit of the line, so a line whose edges are P clocks apart has P units. If the active units run from index a to index b, then back porch = a, active width = b - a + 1 and front porch = P - 1 - b.
- R4: For any line or frame below saturation, back porch + active width + front porch equals the total unit count.
- R5: Vertical units are lines, numbered 0 from the first line that ends after a vertical edge. A line that ends on the same clock as the vertical edge is the last line of the old frame. A frame of L lines whose active lines run from index s to index e reports back porch s, active width e - s + 1 and front porch L - 1 - e.
- R6: Lines with no active pixel leave the horizontal figures unchanged. The published horizontal figures come from the last line in the frame that had activity.
- R7: A frame with no active line publishes a vertical back porch of 0, an active width of 0 and a front porch equal to the number of lines in the frame.
- R8: Readable values change only on the second clock after a vertical edge. The first vertical edge after reset only starts a frame and publishes nothing.
- R9: Unit counts and indices saturate at 4095. Widths are limited to 4095, and a front porch that would go negative reads 0.
- R10: `rd_addr_i` selects a byte. Value k sits at addresses 2k (bits 7:0) and 2k+1 (bits 11:8 in bits 3:0, upper nibble 0). The values are: k=0 horizontal back porch, 1 horizontal active width, 2 horizontal front porch, 3 vertical back porch, 4 vertical active width, 5 vertical front porch. Addresses 12 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| h_flyback_i | input | 1 | Horizontal flyback pulse, rising edge marks a line boundary |
| v_flyback_i | input | 1 | Vertical flyback pulse, rising edge marks a frame boundary |
| video_active_i | input | 1 | Thresholded video activity for the current pixel |
| rd_addr_i | input | 4 | Byte address into the result bank |
| rd_data_o | output | 8 | Selected result byte, combinational from the address |

## Verification
The bench sweeps every placement of an active line span inside short frames. It varies line length, where activity starts and ends, and how long the flyback pulses stay high. The placements include activity on pixel 0 and on the edge clock itself, where a design that misplaced the edge unit would be off by one in both porches. Frames with no activity, or with activity only in middle lines, catch a design that overwrites horizontal results from blank lines or reports a stale vertical extent. The bench also reads the bank in the middle of a frame and in the first frame after reset, to catch a design that publishes early. A 4200-clock line and a 4100-line frame test that the counts clamp at 4095 instead of wrapping into small values.

// File: rtl/vtm_pkg.sv
`timescale 1ns/1ps
package vtm_pkg;
    localparam int CW     = 12;
    localparam int BYTE_W = 8;
    localparam int NVAL   = 6;
    localparam int NBYTE  = 2 * NVAL;
    localparam int SELW   = 4;
    localparam int NEDGE  = 2;

    typedef logic [CW-1:0] cnt_t;
    localparam cnt_t CNT_MAX = '1;
    localparam cnt_t CNT_ONE = cnt_t'(1);

    typedef struct packed {
        cnt_t back;
        cnt_t active;
        cnt_t front;
    } span_t;

    function automatic cnt_t sat_inc(input cnt_t v);
        return (v == CNT_MAX) ? v : v + CNT_ONE;
    endfunction

    function automatic span_t make_span(input logic hit, input cnt_t first,
                                        input cnt_t last, input cnt_t total);
        span_t s;
        logic [CW:0] w;
        s = '0;
        if (!hit) begin
            s.front = total;
        end else begin
            s.back   = first;
            w        = {1'b0, last} - {1'b0, first} + {{CW{1'b0}}, 1'b1};
            s.active = w[CW] ? CNT_MAX : w[CW-1:0];
            s.front  = (total > last) ? (total - last - CNT_ONE) : '0;
        end
        return s;
    endfunction
endpackage

// File: rtl/vtm_edge.sv
`timescale 1ns/1ps
module vtm_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] level_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;

    // R2: a level held high cannot raise a second start
    p_rise_spaced_r2: assert property (@(posedge clk) disable iff (rst)
        (rise_o & $past(rise_o)) == '0);
endmodule

// File: rtl/vtm_span.sv
`timescale 1ns/1ps
module vtm_span
    import vtm_pkg::*;
#(
    parameter bit HOLD_IDLE = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  hit,
    input  logic  restart,
    output span_t res_o,
    output logic  run_hit_o,
    output logic  done_o
);
    cnt_t idx_q, first_q, last_q, tot_q;
    logic seen_q, armed_q, hit_q;
    cnt_t cnt_n, first_n, last_n;
    logic seen_n, keep_ok, upd;

    always_comb begin
        cnt_n   = idx_q;
        first_n = first_q;
        last_n  = last_q;
        seen_n  = seen_q;
        if (tick) begin
            cnt_n = sat_inc(idx_q);
            if (hit) begin
                if (!seen_q) first_n = idx_q;
                last_n = idx_q;
                seen_n = 1'b1;
            end
        end
    end

    generate
        if (HOLD_IDLE) begin : g_keep_active
            assign keep_ok = seen_n;
        end else begin : g_keep_all
            assign keep_ok = 1'b1;
        end
    endgenerate

    assign upd       = restart && armed_q && keep_ok;
    assign run_hit_o = seen_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            first_q <= '0;
            last_q  <= '0;
            tot_q   <= '0;
            seen_q  <= 1'b0;
            armed_q <= 1'b0;
            hit_q   <= 1'b0;
            res_o   <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= upd;
            if (upd) begin
                res_o <= make_span(seen_n, first_n, last_n, cnt_n);
                tot_q <= cnt_n;
                hit_q <= seen_n;
            end
            if (restart) begin
                idx_q   <= '0;
                seen_q  <= 1'b0;
                armed_q <= 1'b1;
            end else begin
                idx_q   <= cnt_n;
                first_q <= first_n;
                last_q  <= last_n;
                seen_q  <= seen_n;
            end
        end
    end

    // R3: recorded first active unit never lies after the last one
    p_first_le_last_r3: assert property (@(posedge clk) disable iff (rst)
        seen_q |-> first_q <= last_q);

    // R9: a saturated count stays put until the next start
    p_count_sat_r9: assert property (@(posedge clk) disable iff (rst)
        (idx_q == CNT_MAX && !restart) |=> idx_q == CNT_MAX);

    // R4: the three parts add up to the unit total below saturation
    p_parts_sum_r4: assert property (@(posedge clk) disable iff (rst)
        (done_o && hit_q && tot_q != CNT_MAX) |->
        (int'(res_o.back) + int'(res_o.active) + int'(res_o.front)) == int'(tot_q));
endmodule

// File: rtl/vtm_bank.sv
`timescale 1ns/1ps
module vtm_bank
    import vtm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              publish_i,
    input  span_t             h_i,
    input  span_t             v_i,
    input  logic [SELW-1:0]   sel_i,
    output logic [BYTE_W-1:0] data_o
);
    span_t h_q, v_q;
    cnt_t  vals [NVAL];
    cnt_t  pick;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= '0;
            v_q <= '0;
        end else if (publish_i) begin
            h_q <= h_i;
            v_q <= v_i;
        end
    end

    always_comb begin
        vals[0] = h_q.back;
        vals[1] = h_q.active;
        vals[2] = h_q.front;
        vals[3] = v_q.back;
        vals[4] = v_q.active;
        vals[5] = v_q.front;
    end

    always_comb begin
        pick   = '0;
        data_o = '0;
        for (int k = 0; k < NVAL; k++) begin
            if ((int'(sel_i) >> 1) == k) pick = vals[k];
        end
        if (int'(sel_i) < NBYTE) begin
            data_o = sel_i[0] ? {{(2*BYTE_W-CW){1'b0}}, pick[CW-1:BYTE_W]}
                              : pick[BYTE_W-1:0];
        end
    end
endmodule

// File: rtl/vtm_measure.sv
`timescale 1ns/1ps
module vtm_measure
    import vtm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              h_flyback_i,
    input  logic              v_flyback_i,
    input  logic              video_active_i,
    input  logic [SELW-1:0]   rd_addr_i,
    output logic [BYTE_W-1:0] rd_data_o
);
    logic [NEDGE-1:0] rise;
    logic             h_rise, v_rise;
    span_t            h_res, v_res;
    logic             h_line_hit, h_done;
    logic             v_unused_hit, v_done;

    vtm_edge #(.N(NEDGE)) edge_i (
        .clk     (clk),
        .rst     (rst),
        .level_i ({v_flyback_i, h_flyback_i}),
        .rise_o  (rise)
    );
    assign h_rise = rise[0];
    assign v_rise = rise[1];

    vtm_span #(.HOLD_IDLE(1'b1)) hspan_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (1'b1),
        .hit       (video_active_i),
        .restart   (h_rise),
        .res_o     (h_res),
        .run_hit_o (h_line_hit),
        .done_o    (h_done)
    );

    vtm_span #(.HOLD_IDLE(1'b0)) vspan_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (h_rise),
        .hit       (h_line_hit),
        .restart   (v_rise),
        .res_o     (v_res),
        .run_hit_o (v_unused_hit),
        .done_o    (v_done)
    );

    vtm_bank bank_i (
        .clk       (clk),
        .rst       (rst),
        .publish_i (v_done),
        .h_i       (h_res),
        .v_i       (v_res),
        .sel_i     (rd_addr_i),
        .data_o    (rd_data_o)
    );

    // R8: a frame result is handed over only right after a vertical edge
    p_publish_on_frame_r8: assert property (@(posedge clk) disable iff (rst)
        v_done |-> $past(v_rise));

    // R6: horizontal result completion implies a line edge just occurred
    p_line_done_edge_r6: assert property (@(posedge clk) disable iff (rst)
        h_done |-> $past(h_rise));
endmodule

// File: tb/vtm_measure_tb_top.sv
`timescale 1ns/1ps
module vtm_measure_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hf = 1'b0, vf = 1'b0, va = 1'b0;
    logic [3:0] ra = '0;
    logic [7:0] rd;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;
    int  pub [6];
    int  prev_hold = 0;
    string pend_tag = "R1 R8 no publish before armed";

    always #5 clk = ~clk;

    vtm_measure dut_i (
        .clk            (clk),
        .rst            (rst),
        .h_flyback_i    (hf),
        .v_flyback_i    (vf),
        .video_active_i (va),
        .rd_addr_i      (ra),
        .rd_data_o      (rd)
    );

    function automatic int sat(input int x);
        return (x > 4095) ? 4095 : x;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // R10 byte map: even address low byte, odd address upper nibble
    task automatic check_bank(input string tag);
        for (int k = 0; k < 6; k++) begin
            ra = 4'(2 * k);
            #0.2;
            chk($sformatf("%s R10 val%0d lo", tag, k), int'(rd), pub[k] & 255);
            ra = 4'(2 * k + 1);
            #0.2;
            chk($sformatf("%s R10 val%0d hi", tag, k), int'(rd), pub[k] >> 8);
        end
    endtask

    task automatic frame(input int L, input int P, input int ls, input int le,
                         input bit any, input int a, input int b, input int hold,
                         input bit arm_only, input string tag);
        int hold_in, f, l, tot;
        for (int j = 0; j < L; j++) begin
            for (int i = 0; i < P; i++) begin
                @(negedge clk);
                hold_in = (j == 0) ? prev_hold : hold;
                hf = (i == P - 1) || (i < hold_in);
                vf = (j == L - 1 && i == P - 1) || (j == 0 && i < prev_hold);
                va = any && j >= ls && j <= le && i >= a && i <= b;
                if (j == 0 && i == 2) check_bank(pend_tag);
                if (L > 1 && j == L - 1 && i == 0) check_bank("R8 mid-frame");
            end
        end
        prev_hold = hold;
        pend_tag  = tag;
        if (!arm_only) begin
            if (any) begin
                f = sat(a); l = sat(b); tot = sat(P);
                pub[0] = f; pub[1] = sat(l - f + 1); pub[2] = (tot > l) ? tot - 1 - l : 0;
                f = sat(ls); l = sat(le); tot = sat(L);
                pub[3] = f; pub[4] = sat(l - f + 1); pub[5] = (tot > l) ? tot - 1 - l : 0;
            end else begin
                pub[3] = 0; pub[4] = 0; pub[5] = sat(L);
            end
        end
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 6; k++) pub[k] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_bank("R1 reset");
        for (int s = 12; s < 16; s++) begin
            ra = 4'(s);
            #0.2;
            chk($sformatf("R10 unused address %0d", s), int'(rd), 0);
        end
        // first frame edge only arms (R8)
        frame(1, 8, 0, 0, 1'b0, 0, 0, 0, 1'b1, "R8 first edge arms only");
        // sweep of span placements: R2 R3 R4 R5 R6
        for (int L = 4; L <= 6; L++) begin
            for (int ls = 0; ls < L; ls++) begin
                for (int le = ls; le < L; le++) begin
                    int P, a, b;
                    P = 8 + (ls + le + L) % 6;
                    a = (2 * ls + le) % 3;
                    b = P - 1 - ((le + L) % 3);
                    frame(L, P, ls, le, 1'b1, a, b, (L + ls) % 3, 1'b0,
                          "R2 R3 R4 R5 R6 sweep");
                end
            end
            frame(L, 9, 0, 0, 1'b0, 0, 0, L % 3, 1'b0, "R6 R7 blank frame");
        end
        frame(3, 4200, 1, 1, 1'b1, 10, 4150, 2, 1'b0, "R9 long line");
        frame(4100, 4, 5, 4098, 1'b1, 1, 1, 1, 1'b0, "R9 tall frame");
        frame(2, 8, 0, 0, 1'b0, 0, 0, 0, 1'b0, "R7 tail blank");
        repeat (3) @(negedge clk);
        check_bank(pend_tag);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule